// File: doc/BRIEF.md
# Line Brown-In/Brown-Out Qualifier

This block is the digital supervisor that decides whether an off-line switching converter may start from the input line, and when it must shut down because the line has sagged. Two comparator flags reach it from the analog front end. The first says the line-sense current is above the run threshold. The second says that current is at or below the stop threshold. A strobe marks each low-side switch on-time, and each test pulse, when those flags are valid.

After every supply restart event, the block qualifies the line on a sequence of test pulses. The first reading is thrown away. One good reading after that sends a soft-start request and enables running. Three low readings in a row refuse the start and park the controller with switching stopped until the supply cycles again.

While running, a persistent low line, measured by a clock-cycle counter, latches a brown-out fault. Short dips caused by line ripple are forgiven. The fault holds until the next supply restart event.

Top module: `line_brownout_qualifier`

## Requirements
- R1: During and after a synchronous reset (rst_n low at a clock edge) the block idles with `sw_stop_o`=1, `run_o`=0, `bo_fault_o`=0, `ss_req_o`=0, and strobes are ignored until a supply restart event.
- R2: A supply restart pulse (`uvlo_evt_i`=1) in any state starts a new test cycle at the next edge: `sw_stop_o`=0, `run_o`=0, `bo_fault_o`=0.
- R3: The reading taken on the first strobe of each test cycle is discarded, even when the run flag is high.
- R4: A strobe on the second, third or fourth test pulse with the run flag high enters running at that edge: `run_o`=1 and `ss_req_o`=1 in the following cycle.
- R5: Three consecutive strobes with the run flag low after the discarded one stop the block (`sw_stop_o`=1, `run_o`=0), and later strobes have no effect until a supply restart event.
- R6: Comparator flags are taken only on a strobe edge. Flag changes without a strobe neither start the block nor advance the brown-out timer.
- R7: While running, `bo_fault_o` rises after exactly `TRIP_CYC` consecutive clock edges during which the sampled stop flag is high, and not one edge earlier.
- R8: A strobe with the stop flag low clears the brown-out timer, so a later low-line episode must again last the full `TRIP_CYC` edges.
- R9: With the fault set, `run_o`=0 and `sw_stop_o`=1, and the fault stays set through any strobe activity until a supply restart event.
- R10: `ss_req_o` is a single-cycle pulse per start decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_evt_i | input | 1 | Supply reached its turn-off level, one-cycle pulse; begins a new start cycle |
| pulse_stb_i | input | 1 | Test-pulse or switch-on strobe; flags are valid in this cycle |
| above_run_i | input | 1 | Sense current above the run threshold |
| below_stop_i | input | 1 | Sense current at or below the stop threshold |
| ss_req_o | output | 1 | Soft-start request pulse |
| run_o | output | 1 | Converter running / enabled |
| sw_stop_o | output | 1 | Switching-stop command |
| bo_fault_o | output | 1 | Latched brown-out fault |

## Verification
The bench builds the block with `TRIP_CYC` set to 16 instead of the default 6,000,000, which is 60 ms at 100 MHz. A persistence window of sixteen edges puts the last non-tripping edge, the tripping edge and a timer clear partway through an episode within a few dozen cycles. With the same value, a run of low readings longer than the window but given without a strobe shows that unsampled flags cannot reach the timer.

// File: rtl/lbq_pkg.sv
package lbq_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_TEST  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } lbq_state_e;

    typedef struct packed {
        lbq_state_e state;
        logic [1:0] pcnt;
        logic       ss;
    } lbq_fsm_t;

endpackage

// File: rtl/lbq_flag_hold.sv
// Sample-and-hold of comparator flags; the current view is the live
// flags on a strobe and the held copy otherwise.
module lbq_flag_hold #(
    parameter int unsigned NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          stb_i,
    input  logic [NF-1:0] flag_i,
    output logic [NF-1:0] cur_o
);

    logic [NF-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (clr_i)
            hold_d = '0;
        else if (stb_i)
            hold_d = flag_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else
            hold_q <= hold_d;
    end

    assign cur_o = stb_i ? flag_i : hold_q;

endmodule

// File: rtl/lbq_persist_timer.sv
// Counts consecutive enabled cycles; done on the LIMIT-th one.
module lbq_persist_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic done_o
);

    localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    assign done_o = en_i && (cnt_q == TW'(LIMIT - 1));

    always_comb begin
        if (!en_i)
            cnt_d = '0;
        else if (done_o)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/line_brownout_qualifier.sv
module line_brownout_qualifier
    import lbq_pkg::*;
#(
    parameter int unsigned TRIP_CYC = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo_evt_i,
    input  logic pulse_stb_i,
    input  logic above_run_i,
    input  logic below_stop_i,
    output logic ss_req_o,
    output logic run_o,
    output logic sw_stop_o,
    output logic bo_fault_o
);

    localparam int unsigned NFLAG     = 2;
    localparam logic [1:0]  LAST_PULSE = 2'd3;

    lbq_fsm_t    fsm_d, fsm_q;
    logic [NFLAG-1:0] cur_flags;
    logic        cur_above, cur_below;
    logic        tmr_en, tmr_done;

    lbq_flag_hold #(.NF(NFLAG)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (uvlo_evt_i),
        .stb_i  (pulse_stb_i),
        .flag_i ({above_run_i, below_stop_i}),
        .cur_o  (cur_flags)
    );

    assign cur_above = cur_flags[1];
    assign cur_below = cur_flags[0];

    assign tmr_en = (fsm_q.state == ST_RUN) && cur_below && !uvlo_evt_i;

    lbq_persist_timer #(.LIMIT(TRIP_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tmr_en),
        .done_o (tmr_done)
    );

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.ss = 1'b0;
        if (uvlo_evt_i) begin
            fsm_d.state = ST_TEST;
            fsm_d.pcnt  = '0;
        end else begin
            unique case (fsm_q.state)
                ST_WAIT: ;
                ST_TEST: begin
                    if (pulse_stb_i) begin
                        if (fsm_q.pcnt == '0) begin
                            fsm_d.pcnt = 2'd1;
                        end else if (cur_above) begin
                            fsm_d.state = ST_RUN;
                            fsm_d.pcnt  = '0;
                            fsm_d.ss    = 1'b1;
                        end else if (fsm_q.pcnt == LAST_PULSE) begin
                            fsm_d.state = ST_WAIT;
                            fsm_d.pcnt  = '0;
                        end else begin
                            fsm_d.pcnt = fsm_q.pcnt + 2'd1;
                        end
                    end
                end
                ST_RUN: begin
                    if (tmr_done)
                        fsm_d.state = ST_FAULT;
                end
                ST_FAULT: ;
                default: fsm_d.state = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            fsm_q <= '{state: ST_WAIT, pcnt: 2'd0, ss: 1'b0};
        else
            fsm_q <= fsm_d;
    end

    assign ss_req_o   = fsm_q.ss;
    assign run_o      = (fsm_q.state == ST_RUN);
    assign sw_stop_o  = (fsm_q.state == ST_WAIT) || (fsm_q.state == ST_FAULT);
    assign bo_fault_o = (fsm_q.state == ST_FAULT);

endmodule

// File: rtl/lbq_checker.sv
module lbq_checker (
    input logic clk,
    input logic rst_n,
    input logic uvlo_evt_i,
    input logic ss_req_o,
    input logic run_o,
    input logic sw_stop_o,
    input logic bo_fault_o
);

    a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        bo_fault_o |-> (sw_stop_o && !run_o));

    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_fault_o && !uvlo_evt_i) |=> bo_fault_o);

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_evt_i |=> (!bo_fault_o && !run_o && !sw_stop_o));

    a_r10_ss_single: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |=> !ss_req_o);

    a_r4_ss_with_run: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |-> run_o);

    a_r7_fault_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bo_fault_o) |-> $past(run_o));

endmodule

bind line_brownout_qualifier lbq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uvlo_evt_i (uvlo_evt_i),
    .ss_req_o   (ss_req_o),
    .run_o      (run_o),
    .sw_stop_o  (sw_stop_o),
    .bo_fault_o (bo_fault_o)
);

// File: tb/tb_line_brownout_qualifier.sv
`timescale 1ns/1ps
module tb_line_brownout_qualifier;

    localparam int unsigned TRIP = 16;
    localparam int NVEC = 16;

    // {req[3:0], uvlo, stb, above, below, run, stop, fault, ss}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd1,  4'b0110, 4'b0100},  // R1 strobe ignored while idle
        {4'd2,  4'b1000, 4'b0000},  // R2 restart into test
        {4'd3,  4'b0110, 4'b0000},  // R3 first reading discarded
        {4'd6,  4'b0010, 4'b0000},  // R6 no strobe, no start
        {4'd5,  4'b0100, 4'b0000},  // R5 low 1
        {4'd5,  4'b0100, 4'b0000},  // R5 low 2
        {4'd5,  4'b0100, 4'b0100},  // R5 low 3 -> stop
        {4'd5,  4'b0110, 4'b0100},  // R5 strobes ignored after refusal
        {4'd2,  4'b1000, 4'b0000},  // R2 restart
        {4'd3,  4'b0100, 4'b0000},  // R3 discarded
        {4'd5,  4'b0100, 4'b0000},  // R5 one low
        {4'd4,  4'b0110, 4'b1001},  // R4 start on third pulse
        {4'd10, 4'b0000, 4'b1000},  // R10 pulse ends
        {4'd2,  4'b1000, 4'b0000},  // R2 restart from running
        {4'd3,  4'b0100, 4'b0000},  // R3 discarded
        {4'd4,  4'b0110, 4'b1001}   // R4 start on second pulse
    };

    logic clk = 1'b0;
    logic rst_n, uvlo, stb, above, below;
    logic ss, run, stp, flt;
    logic [3:0] outs;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_brownout_qualifier #(.TRIP_CYC(TRIP)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .uvlo_evt_i   (uvlo),
        .pulse_stb_i  (stb),
        .above_run_i  (above),
        .below_stop_i (below),
        .ss_req_o     (ss),
        .run_o        (run),
        .sw_stop_o    (stp),
        .bo_fault_o   (flt)
    );

    assign outs = {run, stp, flt, ss};

    task automatic chk(input string tag, input logic [3:0] exp);
        checks++;
        if (outs !== exp) begin
            errors++;
            $display("FAIL %s: run/stop/fault/ss got %b expected %b", tag, outs, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; uvlo = 1'b0; stb = 1'b0; above = 1'b0; below = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", 4'b0100);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            {uvlo, stb, above, below} = VEC[i][7:4];
            edges(1);
            chk($sformatf("R%0d vector %0d", VEC[i][11:8], i), VEC[i][3:0]);
        end
        {uvlo, stb, above, below} = 4'b0000;

        edges(1);
        chk("R10 no repeat of request", 4'b1000);

        // R6: low line without strobe must not advance the timer
        below = 1'b1;
        edges(TRIP + 4);
        chk("R6 unsampled stop flag", 4'b1000);
        below = 1'b0;

        // R8: partial episode then clearing strobe
        stb = 1'b1; below = 1'b1;
        edges(1);
        stb = 1'b0;
        edges(9);
        stb = 1'b1; below = 1'b0;
        edges(1);
        chk("R8 cleared before trip", 4'b1000);

        // R7: full episode, boundary edge
        below = 1'b1;
        edges(1);
        stb = 1'b0; below = 1'b0;
        edges(TRIP - 2);
        chk("R7 one edge short", 4'b1000);
        edges(1);
        chk("R7 trip edge", 4'b0110);

        // R9: fault holds through strobes
        stb = 1'b1; above = 1'b1;
        edges(5);
        chk("R9 fault sticky", 4'b0110);
        stb = 1'b0; above = 1'b0;

        uvlo = 1'b1;
        edges(1);
        uvlo = 1'b0;
        chk("R2 restart clears fault", 4'b0000);

        // R1: reset while running
        stb = 1'b1; above = 1'b1;
        edges(2);
        stb = 1'b0; above = 1'b0;
        chk("R4 start after restart", 4'b1001);
        rst_n = 1'b0;
        edges(1);
        chk("R1 reset from running", 4'b0100);
        rst_n = 1'b1;
        stb = 1'b1; above = 1'b1;
        edges(2);
        stb = 1'b0; above = 1'b0;
        chk("R1 idle ignores strobes", 4'b0100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule